// File: doc/BRIEF.md
# Sampled Input Glitch Qualifier

This block cleans up a bank of asynchronous digital inputs before the rest of the chip uses them. Every raw line first crosses into the system clock domain through a two-flop synchronizer. The synchronized level is then sampled on a strobe whose spacing is set per group of eight inputs. The filtered output of an input moves to a new level only when a chosen number of consecutive samples, three or six, all agree on that level. Anything shorter is dropped as noise.

Each group has an eight-bit period field. A zero field samples on every clock. A nonzero value N samples once every 2·N clocks, so the longest spacing is 510 clocks. Each input has its own bit that chooses between the short (3-sample) and long (6-sample) qualification. If a period field is rewritten, the interval counter of that group restarts, and the new spacing applies from the next strobe onward.

Top module: `input_qualifier`

## Requirements
- R1: Each input passes two synchronizer flops before it is sampled. With a zero period field and 3-sample qualification, a level change held on `din` appears on `qout` at the 5th rising clock edge after it is applied, and not earlier.
- R2: When a group's period field is zero, its inputs are sampled on every clock once the field has been stable for a cycle.
- R3: When a group's period field holds N ≠ 0, its inputs are sampled once every 2·N clocks, and two samples never fall on adjacent cycles.
- R4: Inputs 0–7 use period bits [7:0] and inputs 8–15 use period bits [15:8]. The timing of one group does not affect the other.
- R5: `six_sel[i]` = 1 requires 6 agreeing samples for input i and `six_sel[i]` = 0 requires 3. With a zero period, a held change reaches `qout` at the 8th edge when 6 samples are selected.
- R6: A pulse that covers fewer samples than the selected count never reaches `qout`, and `qout` holds its previous value. `qout` changes only on a sample strobe of its group, and only to the level just sampled.
- R7: A write of a new value to a period field clears that group's counter. With a change from 0 to 2 applied together with a rising input (3 samples), `qout` rises at the 14th edge.
- R8: While `rst_n` is low, every `qout` bit is low, sample histories are low, and the period counters are at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| din | input | 16 | Raw asynchronous inputs |
| period | input | 16 | Two 8-bit sample period fields, group 0 in the low byte |
| six_sel | input | 16 | Per-input sample count choice: 1 = six samples, 0 = three |
| qout | output | 16 | Qualified outputs |

## Verification
A period field rewrite and a sample strobe can compete for the same clock. The bench changes a field from 0 to 2 on the same cycle that it raises an input, while the old setting would still strobe on every cycle. It then requires the output edge to land exactly where a restarted counter puts it. A second case places a falling input in the fast group and a rising input in the slow group on one cycle. It judges that each follows only its own group's strobes, while a reference model is compared against `qout` on every clock.

// File: rtl/qual_pkg.sv
package qual_pkg;
  localparam int unsigned SHORT_CNT = 3;
  localparam int unsigned LONG_CNT  = 6;

  typedef enum logic {
    CNT_SHORT = 1'b0,
    CNT_LONG  = 1'b1
  } cnt_sel_e;
endpackage

// File: rtl/qual_sync.sv
module qual_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d;
  logic [W-1:0] sync_q;
  logic [W-1:0] sync_d;

  always_comb begin
    meta_d = d_async;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/qual_strobe.sv
module qual_strobe #(
  parameter int unsigned PRD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRD_W-1:0] prd,
  output logic             stb
);
  localparam int unsigned CNT_W = PRD_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRD_W-1:0] prd_q, prd_d;
  logic             stb_q, stb_d;
  logic [CNT_W-1:0] last_cnt;
  logic             prd_new;
  logic             prd_zero;
  logic             at_end;

  always_comb begin
    last_cnt = {prd, 1'b0} - CNT_W'(1);
    prd_new  = (prd != prd_q);
    prd_zero = (prd == '0);
    at_end   = prd_zero || (cnt_q == last_cnt);
    prd_d    = prd;
    if (prd_new) begin
      cnt_d = '0;
      stb_d = 1'b0;
    end else if (at_end) begin
      cnt_d = '0;
      stb_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      stb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      prd_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      prd_q <= prd_d;
      stb_q <= stb_d;
    end
  end

  assign stb = stb_q;
endmodule

// File: rtl/qual_filter.sv
module qual_filter
  import qual_pkg::*;
#(
  parameter int unsigned LONG  = LONG_CNT,
  parameter int unsigned SHORT = SHORT_CNT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic d_in,
  input  logic sel_long,
  output logic q
);
  localparam logic [LONG-1:0] MASK_LONG  = {LONG{1'b1}};
  localparam logic [LONG-1:0] MASK_SHORT = LONG'({SHORT{1'b1}});

  logic [LONG-1:0] hist_q, hist_d, mask;
  logic            q_q, q_d;
  logic            all_hi, all_lo;
  cnt_sel_e        sel;

  always_comb begin
    sel    = sel_long ? CNT_LONG : CNT_SHORT;
    mask   = (sel == CNT_LONG) ? MASK_LONG : MASK_SHORT;
    hist_d = {hist_q[LONG-2:0], d_in};
    all_hi = ((hist_d & mask) == mask);
    all_lo = ((hist_d & mask) == '0);
    if (all_hi)      q_d = 1'b1;
    else if (all_lo) q_d = 1'b0;
    else             q_d = q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      q_q    <= 1'b0;
    end else if (smp_en) begin
      hist_q <= hist_d;
      q_q    <= q_d;
    end
  end

  assign q = q_q;
endmodule

// File: rtl/input_qualifier.sv
module input_qualifier #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned GRP   = 8,
  parameter int unsigned PRD_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IN-1:0]               din,
  input  logic [(N_IN/GRP)*PRD_W-1:0]   period,
  input  logic [N_IN-1:0]               six_sel,
  output logic [N_IN-1:0]               qout
);
  localparam int unsigned N_GRP = N_IN / GRP;

  logic [N_IN-1:0]  din_s;
  logic [N_GRP-1:0] grp_stb;

  qual_sync #(.W(N_IN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(din),
    .d_sync (din_s)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    qual_strobe #(.PRD_W(PRD_W)) u_stb (
      .clk  (clk),
      .rst_n(rst_n),
      .prd  (period[g*PRD_W +: PRD_W]),
      .stb  (grp_stb[g])
    );
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    qual_filter u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_en  (grp_stb[i/GRP]),
      .d_in    (din_s[i]),
      .sel_long(six_sel[i]),
      .q       (qout[i])
    );
  end
endmodule

// File: rtl/input_qualifier_chk.sv
module input_qualifier_chk #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned GRP   = 8,
  parameter int unsigned PRD_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [(N_IN/GRP)*PRD_W-1:0] period,
  input logic [N_IN-1:0]             qout,
  input logic [N_IN/GRP-1:0]         stb,
  input logic [N_IN-1:0]             sync
);
  localparam int unsigned N_GRP = N_IN / GRP;

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (qout == '0);
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    // R6
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(qout[i]) |-> $past(stb[i/GRP]));
    // R6
    follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(qout[i]) |-> (qout[i] == $past(sync[i])));
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    // R2
    zero_period_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(period[g*PRD_W +: PRD_W]) == '0)
                    && ($past(period[g*PRD_W +: PRD_W], 2) == '0)) |-> stb[g]);
    // R3
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb[g] && ($past(period[g*PRD_W +: PRD_W]) != '0)) |=> !stb[g]);
  end
endmodule

bind input_qualifier input_qualifier_chk #(.N_IN(N_IN), .GRP(GRP), .PRD_W(PRD_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .period(period),
  .qout  (qout),
  .stb   (grp_stb),
  .sync  (din_s)
);

// File: tb/sim_input_qualifier.sv
module sim_input_qualifier;
  localparam int N = 16;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  din;
  logic [15:0]   period;
  logic [N-1:0]  six_sel;
  logic [N-1:0]  qout;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  input_qualifier u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .period (period),
    .six_sel(six_sel),
    .qout   (qout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference model
  bit m_s1 [N];
  bit m_s2 [N];
  bit m_q  [N];
  bit m_lv [N];
  int m_run[N];
  bit m_st [2];
  int m_cnt[2];
  int m_prd[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_q[i] = 0; m_lv[i] = 0; m_run[i] = 6;
      end
      for (int g = 0; g < 2; g++) begin
        m_st[g] = 0; m_cnt[g] = 0; m_prd[g] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (m_st[i/8]) begin
          if (m_s2[i] == m_lv[i]) m_run[i] = (m_run[i] < 6) ? m_run[i] + 1 : 6;
          else begin m_lv[i] = m_s2[i]; m_run[i] = 1; end
          if (m_run[i] >= (six_sel[i] ? 6 : 3)) m_q[i] = m_lv[i];
        end
      end
      for (int g = 0; g < 2; g++) begin
        int p;
        p = int'(period[g*8 +: 8]);
        if (p != m_prd[g]) begin m_cnt[g] = 0; m_st[g] = 0; end
        else if (p == 0 || m_cnt[g] == 2*p - 1) begin m_cnt[g] = 0; m_st[g] = 1; end
        else begin m_cnt[g] = m_cnt[g] + 1; m_st[g] = 0; end
        m_prd[g] = p;
      end
      for (int i = 0; i < N; i++) begin
        m_s2[i] = m_s1[i];
        m_s1[i] = din[i];
      end
    end
  end

  // per-clock comparison against the model (R3 R6 R7)
  always @(negedge clk) begin
    logic [N-1:0] expq;
    for (int i = 0; i < N; i++) expq[i] = m_q[i];
    checks++;
    if (qout !== expq) begin
      errors++;
      $display("FAIL R6 R7 per-cycle qout=%h expected=%h at cycle %0d", qout, expq, cycles);
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int got, input int lo, input int hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    bit seen;
    int k;
    rst_n   = 1'b0;
    din     = '0;
    period  = '0;
    six_sel = '0;
    repeat (4) @(negedge clk);
    // R8: outputs low during reset
    chk("R8 reset qout", |qout, 1'b0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 after release", |qout, 1'b0);

    // R1 R2: zero period, 3 samples -> 5th edge
    din[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 not before edge 5", qout[0], 1'b0);
    @(negedge clk);
    chk("R2 at edge 5", qout[0], 1'b1);

    // R5: six samples -> 8th edge
    six_sel[1] = 1'b1;
    repeat (3) @(negedge clk);
    din[1] = 1'b1;
    repeat (7) @(negedge clk);
    chk("R5 not before edge 8", qout[1], 1'b0);
    @(negedge clk);
    chk("R5 at edge 8", qout[1], 1'b1);

    // R6: short pulses rejected
    din[2] = 1'b1;
    repeat (2) @(negedge clk);
    din[2] = 1'b0;
    six_sel[3] = 1'b1;
    din[3] = 1'b1;
    seen = 0;
    for (int c = 0; c < 14; c++) begin
      if (c == 5) din[3] = 1'b0;
      @(negedge clk);
      if (qout[2] || qout[3]) seen = 1;
    end
    chk("R6 short pulses held", seen, 1'b0);

    // R3: group 1 period 3 -> change between edge 15 and 20
    period[15:8] = 8'd3;
    repeat (20) @(negedge clk);
    din[8] = 1'b1;
    k = 0;
    while (qout[8] == 1'b0 && k < 40) begin @(negedge clk); k++; end
    chk_int("R3 edges to change", k, 15, 20);

    // R4: same-cycle changes in both groups follow own group
    din[0] = 1'b0;
    din[9] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 group0 fast fall", qout[0], 1'b0);
    chk("R4 group1 still slow", qout[9], 1'b0);
    repeat (20) @(negedge clk);
    chk("R4 group1 eventually", qout[9], 1'b1);

    // R7: rewrite 0 -> 2 on group 0 with rising input -> edge 14
    period[7:0] = 8'd2;
    din[4] = 1'b1;
    repeat (13) @(negedge clk);
    chk("R7 not before edge 14", qout[4], 1'b0);
    @(negedge clk);
    chk("R7 at edge 14", qout[4], 1'b1);

    // R3: longest interval, six samples
    six_sel[15] = 1'b1;
    period[15:8] = 8'd255;
    repeat (600) @(negedge clk);
    din[15] = 1'b1;
    repeat (2000) @(negedge clk);
    chk("R3 long interval not early", qout[15], 1'b0);
    repeat (1300) @(negedge clk);
    chk("R3 long interval reached", qout[15], 1'b1);

    // mixed random activity, compared against the model every clock
    for (int cfg = 0; cfg < 5; cfg++) begin
      period  = {8'($urandom_range(0, 4)), 8'($urandom_range(0, 3))};
      six_sel = 16'($urandom);
      for (int c = 0; c < 500; c++) begin
        @(negedge clk);
        din = din ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
        if (c % 97 == 50) period[7:0] = 8'($urandom_range(0, 3));
      end
    end
    din = '0;
    repeat (60) @(negedge clk);
    chk("R6 settle low", |qout, 1'b0);
    finish_run();
  end
endmodule